// File: doc/BRIEF.md
# Phased SPI Master Transaction Sequencer

This block is a serial peripheral master that carries out one framed transaction each time it is started. A frame is built from up to five optional segments that always run in the same order: an opcode segment, a location segment, a turnaround (idle clock) segment, an outbound payload segment and an inbound payload segment. Each segment has its own enable and a length field that holds the count minus one, so one engine covers short opcode-only accesses as well as long streamed transfers. All settings come in on plain input ports and must be held steady while the block is busy.

The serial clock is divided from the system clock with a programmable period and high time, or it runs at the system rate when bypass is selected. The chip select is active low. It is held low without a gap from a lead-in interval, through every enabled segment, to a trailing interval. Both intervals can be stretched. When the select line goes high again, the block raises a one-cycle completion pulse.

The sequencer is a single state machine with the states IDLE, SETUP, CMD, ADDR, DUMMY, WRITE, READ and HOLD. There are four transitions. IDLE goes to SETUP on `start`. SETUP goes to the first enabled segment, or to HOLD if none is enabled. Each segment goes to the next enabled segment after its last serial period, or to HOLD if it was the last one. HOLD goes to IDLE after its last serial period, and `done` is raised at that point.

Top module: `spi_phase_master`

## Requirements
- R1: A one-cycle `start` while IDLE makes `busy` high from the next cycle until the transaction ends. A `start` while busy is ignored: the transaction length and the single `done` are unchanged.
- R2: The opcode segment, when enabled, sends `cmd_len`+1 bits taken from `cmd_val[cmd_len]` down to `cmd_val[0]`, most significant bit first.
- R3: The location segment, when enabled, sends `addr_len`+1 bits starting at `addr_val[31]` and going downward. Bit positions past `addr_val[0]` send 0.
- R4: The turnaround segment, when enabled, lasts `dummy_len`+1 serial periods. The clock toggles in every one of them and `mosi` is 0.
- R5: The outbound segment, when enabled, sends `wr_len`+1 bits starting at `wdata[31]` and going downward. Bits past `wdata[0]` send 0.
- R6: The inbound segment, when enabled, captures `rd_len`+1 bits. Each captured bit is shifted into `rx_data` at bit 0. `rx_data` is cleared when a transaction is started.
- R7: A segment whose enable is 0 adds no serial periods and no bits to the frame. The enabled segments always run in the order opcode, location, turnaround, outbound, inbound.
- R8: With `duplex` set, `miso` is also captured into `rx_data` once in each outbound serial period.
- R9: In divided mode a serial period lasts `div_period`+1 system cycles: `sclk` is low first, then high for `div_high`+1 cycles, with `div_high` < `div_period`. With `clk_bypass` set, a period is one system cycle and `sclk` is high during the second half of that cycle. `mosi` changes at the start of a period. `miso` is captured at the end of a period, and the slave may change it on the rising edge.
- R10: `cs_n` is low for exactly `busy` cycles. That count is P*(`cs_setup`+1 + N + `cs_hold`+1), where P is the period length and N is the sum of the enabled segment lengths. `sclk` stays low during the lead-in and trailing intervals.
- R11: `done` is high for exactly one cycle, the cycle in which `cs_n` returns high. `sclk` is low whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, one cycle |
| cmd_en | input | 1 | Opcode segment enable |
| cmd_len | input | 4 | Opcode bit count minus one |
| cmd_val | input | 16 | Opcode value, right-aligned |
| addr_en | input | 1 | Location segment enable |
| addr_len | input | 6 | Location bit count minus one |
| addr_val | input | 32 | Location value, left-aligned |
| dummy_en | input | 1 | Turnaround segment enable |
| dummy_len | input | 8 | Turnaround period count minus one |
| wr_en | input | 1 | Outbound segment enable |
| wr_len | input | 24 | Outbound bit count minus one |
| wdata | input | 32 | Outbound data, left-aligned |
| rd_en | input | 1 | Inbound segment enable |
| rd_len | input | 24 | Inbound bit count minus one |
| duplex | input | 1 | Capture `miso` during the outbound segment |
| clk_bypass | input | 1 | Run the serial clock at the system rate |
| div_period | input | 6 | Serial period in system cycles minus one |
| div_high | input | 6 | Serial clock high time minus one |
| cs_setup | input | 4 | Extra lead-in periods |
| cs_hold | input | 4 | Extra trailing periods |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| rx_data | output | 32 | Captured inbound bits |

## Verification
The assertions assume that every configuration input stays constant while `busy` is high, and that in divided mode `div_high` is smaller than `div_period`. They also assume that `miso` changes only on a rising serial clock edge. The bench therefore applies each configuration row while the block is idle and holds it until `done`. Every divided-mode row uses a high time shorter than its period. The bench's slave model updates `miso` only inside its rising-`sclk` process.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    // Encoding order is the segment order; the sequencer searches upward.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_CMD   = 3'd2,
        ST_ADDR  = 3'd3,
        ST_DUMMY = 3'd4,
        ST_WRITE = 3'd5,
        ST_READ  = 3'd6,
        ST_HOLD  = 3'd7
    } seq_state_e;
endpackage

// File: rtl/sclk_div.sv
module sclk_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             shifting,
    input  logic             bypass,
    input  logic [DIV_W-1:0] per_m1,
    input  logic [DIV_W-1:0] hi_m1,
    output logic             step,
    output logic             sclk
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] low_len;

    assign low_len = per_m1 - hi_m1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (!run || bypass)        cnt <= '0;
        else if (cnt == per_m1)         cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    assign step = run && (bypass || (cnt == per_m1));
    assign sclk = shifting && (bypass ? ~clk : (cnt >= low_len));

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bypass) |-> (cnt <= per_m1));
    // R9
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/mosi_sel.sv
module mosi_sel
    import spi_seq_pkg::*;
#(
    parameter int CMD_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 24
) (
    input  seq_state_e              state,
    input  logic [LEN_W-1:0]        bitn,
    input  logic [$clog2(CMD_W)-1:0] cmd_len,
    input  logic [CMD_W-1:0]        cmd_val,
    input  logic [ADDR_W-1:0]       addr_val,
    input  logic [DATA_W-1:0]       wdata,
    output logic                    mosi
);
    localparam int CIW = $clog2(CMD_W);
    localparam int AIW = $clog2(ADDR_W);
    localparam int DIW = $clog2(DATA_W);

    logic [CIW-1:0] cidx;
    logic [AIW-1:0] aidx;
    logic [DIW-1:0] didx;

    always_comb begin
        cidx = cmd_len - bitn[CIW-1:0];
        aidx = AIW'(ADDR_W - 1) - bitn[AIW-1:0];
        didx = DIW'(DATA_W - 1) - bitn[DIW-1:0];
        mosi = 1'b0;
        case (state)
            ST_CMD:   mosi = cmd_val[cidx];
            ST_ADDR:  if (bitn < LEN_W'(ADDR_W)) mosi = addr_val[aidx];
            ST_WRITE: if (bitn < LEN_W'(DATA_W)) mosi = wdata[didx];
            default:  mosi = 1'b0;
        endcase
    end
endmodule

// File: rtl/rx_shift.sv
module rx_shift #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              miso,
    output logic [DATA_W-1:0] rx_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rx_data <= '0;
        else if (clear)   rx_data <= '0;
        else if (capture) rx_data <= {rx_data[DATA_W-2:0], miso};
    end

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !capture) |=> $stable(rx_data));
    // R6
    rx_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !clear) |=> (rx_data[0] == $past(miso)));
endmodule

// File: rtl/spi_phase_master.sv
module spi_phase_master
    import spi_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CMD_W  = 16,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24,
    parameter int ALEN_W = 6,
    parameter int DUM_W  = 8,
    parameter int DIV_W  = 6,
    parameter int CSC_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     cmd_en,
    input  logic [$clog2(CMD_W)-1:0] cmd_len,
    input  logic [CMD_W-1:0]         cmd_val,
    input  logic                     addr_en,
    input  logic [ALEN_W-1:0]        addr_len,
    input  logic [ADDR_W-1:0]        addr_val,
    input  logic                     dummy_en,
    input  logic [DUM_W-1:0]         dummy_len,
    input  logic                     wr_en,
    input  logic [LEN_W-1:0]         wr_len,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     rd_en,
    input  logic [LEN_W-1:0]         rd_len,
    input  logic                     duplex,
    input  logic                     clk_bypass,
    input  logic [DIV_W-1:0]         div_period,
    input  logic [DIV_W-1:0]         div_high,
    input  logic [CSC_W-1:0]         cs_setup,
    input  logic [CSC_W-1:0]         cs_hold,
    output logic                     busy,
    output logic                     done,
    output logic                     cs_n,
    output logic                     sclk,
    output logic                     mosi,
    input  logic                     miso,
    output logic [DATA_W-1:0]        rx_data
);
    localparam int NST = 8;

    seq_state_e       state, state_nx, follow;
    logic [LEN_W-1:0] bitn;
    logic [LEN_W-1:0] cur_last;
    logic [NST-1:0]   st_en;
    logic             step, phase_end, shifting, capture, launch;

    // ---------------- serial clock ----------------
    sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state != ST_IDLE),
        .shifting (shifting),
        .bypass   (clk_bypass),
        .per_m1   (div_period),
        .hi_m1    (div_high),
        .step     (step),
        .sclk     (sclk)
    );

    // ---------------- segment search ----------------
    always_comb begin
        st_en           = '0;
        st_en[ST_SETUP] = 1'b1;
        st_en[ST_CMD]   = cmd_en;
        st_en[ST_ADDR]  = addr_en;
        st_en[ST_DUMMY] = dummy_en;
        st_en[ST_WRITE] = wr_en;
        st_en[ST_READ]  = rd_en;
        st_en[ST_HOLD]  = 1'b1;
        follow = ST_IDLE;
        for (int k = NST - 1; k >= 1; k--) begin
            if (k > int'(state) && st_en[k]) follow = seq_state_e'(k[2:0]);
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  cur_last = '0;
            ST_SETUP: cur_last = LEN_W'(cs_setup);
            ST_CMD:   cur_last = LEN_W'(cmd_len);
            ST_ADDR:  cur_last = LEN_W'(addr_len);
            ST_DUMMY: cur_last = LEN_W'(dummy_len);
            ST_WRITE: cur_last = wr_len;
            ST_READ:  cur_last = rd_len;
            ST_HOLD:  cur_last = LEN_W'(cs_hold);
        endcase
    end

    assign phase_end = step && (bitn == cur_last);
    assign launch    = (state == ST_IDLE) && start;

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SETUP;
            ST_SETUP, ST_CMD, ST_ADDR, ST_DUMMY,
            ST_WRITE, ST_READ, ST_HOLD:
                      if (phase_end) state_nx = follow;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               bitn <= '0;
        else if (state == ST_IDLE || phase_end)   bitn <= '0;
        else if (step)                            bitn <= bitn + 1'b1;
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state == ST_HOLD) && phase_end;
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        cs_n     = (state == ST_IDLE);
        shifting = (state == ST_CMD)   || (state == ST_ADDR) || (state == ST_DUMMY) ||
                   (state == ST_WRITE) || (state == ST_READ);
        capture  = step && ((state == ST_READ) || ((state == ST_WRITE) && duplex));
    end

    mosi_sel #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_mosi (
        .state    (state),
        .bitn     (bitn),
        .cmd_len  (cmd_len),
        .cmd_val  (cmd_val),
        .addr_val (addr_val),
        .wdata    (wdata),
        .mosi     (mosi)
    );

    rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .capture (capture),
        .miso    (miso),
        .rx_data (rx_data)
    );

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));
    // R11
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R1
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    // R1
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: tb/sim_spi_phase_master.sv
module sim_spi_phase_master;
    typedef struct packed {
        logic        c_en;  logic [3:0]  c_len; logic [15:0] c_val;
        logic        a_en;  logic [5:0]  a_len; logic [31:0] a_val;
        logic        d_en;  logic [7:0]  d_len;
        logic        w_en;  logic [23:0] w_len; logic [31:0] w_dat;
        logic        r_en;  logic [23:0] r_len;
        logic        dup;   logic        byp;
        logic [5:0]  per;   logic [5:0]  hi;
        logic [3:0]  su;    logic [3:0]  ho;
        logic        poke;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 4'd7, 16'h00A5, 1'b1, 6'd23, 32'h1234_5600, 1'b1, 8'd3,
          1'b1, 24'd15, 32'hBEEF_0000, 1'b1, 24'd11, 1'b0, 1'b0, 6'd3, 6'd1, 4'd1, 4'd2, 1'b1},
        '{1'b1, 4'd15, 16'hC3F0, 1'b0, 6'd0, 32'h0, 1'b0, 8'd0,
          1'b0, 24'd0, 32'h0, 1'b0, 24'd0, 1'b0, 1'b1, 6'd0, 6'd0, 4'd0, 4'd0, 1'b0},
        '{1'b0, 4'd0, 16'h0, 1'b0, 6'd0, 32'h0, 1'b0, 8'd0,
          1'b1, 24'd31, 32'h8000_0001, 1'b0, 24'd0, 1'b1, 1'b0, 6'd1, 6'd0, 4'd2, 4'd0, 1'b0},
        '{1'b0, 4'd0, 16'h0, 1'b1, 6'd39, 32'hFFFF_FFFF, 1'b0, 8'd0,
          1'b0, 24'd0, 32'h0, 1'b1, 24'd7, 1'b0, 1'b1, 6'd0, 6'd0, 4'd3, 4'd1, 1'b0},
        '{1'b0, 4'd0, 16'h0, 1'b0, 6'd0, 32'h0, 1'b0, 8'd0,
          1'b0, 24'd0, 32'h0, 1'b1, 24'd35, 1'b0, 1'b0, 6'd5, 6'd2, 4'd0, 4'd3, 1'b1},
        '{1'b0, 4'd0, 16'h0, 1'b0, 6'd0, 32'h0, 1'b0, 8'd0,
          1'b0, 24'd0, 32'h0, 1'b0, 24'd0, 1'b0, 1'b0, 6'd2, 6'd0, 4'd1, 4'd1, 1'b0},
        '{1'b0, 4'd0, 16'h0, 1'b0, 6'd0, 32'h0, 1'b1, 8'd0,
          1'b1, 24'd0, 32'h8000_0000, 1'b1, 24'd0, 1'b1, 1'b0, 6'd1, 6'd0, 4'd0, 4'd0, 1'b0}
    };

    localparam logic [255:0] PAT =
        256'h9C3A_71E5_0F2D_B468_A5C3_1E7F_6029_D4B1_3355_CCAA_0FF0_8E17_42BD_7A0C_E193_5D26;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic cmd_en = 0, addr_en = 0, dummy_en = 0, wr_en = 0, rd_en = 0, duplex = 0, clk_bypass = 0;
    logic [3:0]  cmd_len = '0;  logic [15:0] cmd_val = '0;
    logic [5:0]  addr_len = '0; logic [31:0] addr_val = '0;
    logic [7:0]  dummy_len = '0;
    logic [23:0] wr_len = '0, rd_len = '0;
    logic [31:0] wdata = '0;
    logic [5:0]  div_period = 6'd1, div_high = '0;
    logic [3:0]  cs_setup = '0, cs_hold = '0;
    logic        miso = 1'b0;
    logic        busy, done, cs_n, sclk, mosi;
    logic [31:0] rx_data;

    int checks = 0, errors = 0, cycles = 0;
    int nr = 0;
    logic got [0:255];
    logic exp_b [0:255];

    always #4 clk = ~clk;

    spi_phase_master u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_en(cmd_en), .cmd_len(cmd_len), .cmd_val(cmd_val),
        .addr_en(addr_en), .addr_len(addr_len), .addr_val(addr_val),
        .dummy_en(dummy_en), .dummy_len(dummy_len),
        .wr_en(wr_en), .wr_len(wr_len), .wdata(wdata),
        .rd_en(rd_en), .rd_len(rd_len), .duplex(duplex),
        .clk_bypass(clk_bypass), .div_period(div_period), .div_high(div_high),
        .cs_setup(cs_setup), .cs_hold(cs_hold),
        .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .rx_data(rx_data)
    );

    // Slave model: record mosi at each rise, then present the next pattern bit.
    always @(posedge sclk) begin
        if (!cs_n) begin
            if (nr < 256) got[nr] = mosi;
            miso = PAT[nr[7:0]];
            nr = nr + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_vec(input vec_t v);
        int n, p, bcnt, ccnt, hcnt, dcnt, bad, firstbad, post;
        logic [31:0] erx;
        bit seen;
        cmd_en = v.c_en; cmd_len = v.c_len; cmd_val = v.c_val;
        addr_en = v.a_en; addr_len = v.a_len; addr_val = v.a_val;
        dummy_en = v.d_en; dummy_len = v.d_len;
        wr_en = v.w_en; wr_len = v.w_len; wdata = v.w_dat;
        rd_en = v.r_en; rd_len = v.r_len; duplex = v.dup;
        clk_bypass = v.byp; div_period = v.per; div_high = v.hi;
        cs_setup = v.su; cs_hold = v.ho;
        // expected frame, built from the requirements
        n = 0; erx = '0;
        if (v.c_en) for (int i = int'(v.c_len); i >= 0; i--) begin exp_b[n] = v.c_val[i]; n++; end
        if (v.a_en) for (int i = 0; i <= int'(v.a_len); i++) begin
            exp_b[n] = (i < 32) ? v.a_val[31-i] : 1'b0; n++; end
        if (v.d_en) for (int i = 0; i <= int'(v.d_len); i++) begin exp_b[n] = 1'b0; n++; end
        if (v.w_en) for (int i = 0; i <= int'(v.w_len); i++) begin
            exp_b[n] = (i < 32) ? v.w_dat[31-i] : 1'b0;
            if (v.dup) erx = {erx[30:0], PAT[n]};
            n++; end
        if (v.r_en) for (int i = 0; i <= int'(v.r_len); i++) begin
            exp_b[n] = 1'b0; erx = {erx[30:0], PAT[n]}; n++; end
        p = v.byp ? 1 : int'(v.per) + 1;
        nr = 0; bcnt = 0; ccnt = 0; hcnt = 0; dcnt = 0; seen = 0; post = 0;
        @(negedge clk);
        start = 1'b1;
        for (int c = 0; c < 20000 && post < 3; c++) begin
            @(negedge clk);
            if (c == 0) start = 1'b0;
            if (v.poke && c == 20) start = 1'b1;
            if (v.poke && c == 21) start = 1'b0;
            if (busy) bcnt++;
            if (!cs_n) ccnt++;
            if (sclk) hcnt++;
            if (done) begin dcnt++; seen = 1; end
            if (seen) post++;
        end
        bad = 0; firstbad = -1;
        for (int i = 0; i < n; i++) if (got[i] !== exp_b[i]) begin
            bad++; if (firstbad < 0) firstbad = i; end
        check(bad == 0, "R2/R3/R4/R5/R7", "mosi frame mismatches", bad, 0);
        check(nr == n, "R4/R7", "serial clock rises", nr, n);
        check(bcnt == p * (int'(v.su) + 1 + n + int'(v.ho) + 1), "R10/R1", "busy cycles",
              bcnt, p * (int'(v.su) + 1 + n + int'(v.ho) + 1));
        check(ccnt == bcnt, "R10", "cs_n low cycles", ccnt, bcnt);
        check(dcnt == 1, "R11/R1", "done pulses", dcnt, 1);
        check(rx_data === erx, "R6/R8", "rx_data", rx_data, erx);
        if (!v.byp)
            check(hcnt == n * (int'(v.hi) + 1), "R9", "sclk high cycles", hcnt, n * (int'(v.hi) + 1));
        if (firstbad >= 0) $display("  first frame mismatch at bit %0d", firstbad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1, R11)
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(cs_n == 1'b1, "R11", "cs_n after reset", cs_n, 1);
        check(sclk == 1'b0, "R11", "sclk after reset", sclk, 0);
        check(done == 1'b0, "R11", "done after reset", done, 0);
        check(rx_data == '0, "R6", "rx_data after reset", rx_data, 0);
        for (int k = 0; k < NV; k++) run_vec(TBL[k]);
        // directed: back-to-back start right after completion relaunches (R1)
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R1", "relaunch busy", busy, 1);
        wait (done == 1'b1);
        @(negedge clk);
        // directed: reset mid-transaction returns idle outputs (R11)
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(cs_n == 1'b1 && busy == 1'b0, "R11", "idle after reset abort", {cs_n, busy}, 2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule